// File: doc/BRIEF.md
# Audio Sample-Rate Change Detector

This block watches the word clock of an incoming serial audio stream and times it against the local clock. Every few word-clock periods it turns the cycle count into a rate class. The class has a family (the 44.1 kHz or the 48 kHz series) and a speed multiple (1x, 2x, 4x or 8x). A new class is adopted only after two measurements in a row agree. The block also follows a format flag that says whether the stream carries DSD or PCM.

An event is raised when the adopted class changes, or when the stream switches between DSD and PCM. The event mutes the serial output and pulls an active-low wake line to an external controller, both in the same cycle. Both stay asserted until the controller acknowledges. The controller then reads the family, which selects one of two oscillators, the speed code and the master-clock ratio. The ratio depends on which speed class of oscillator pair is fitted. The block has no data stream, so it has no valid/ready handshake. Every pin is a plain level, and the acknowledge is a single-cycle strobe or a level that is sampled each cycle.

Top module: `srate_watch`

## Requirements
- R1: Over each group of NPER word-clock periods the block counts local clock cycles. When the count lies within ±TOL_PCT percent of NPER·CLK_HZ/rate for one of the eight rates, it reports that rate: `rate_code_o[2]` is the family (0 = 44.1 kHz series, 1 = 48 kHz series), `rate_code_o[1:0]` is the speed (0 = 1x, 1 = 2x, 2 = 4x, 3 = 8x) and `rate_ok_o` = 1.
- R2: A new class is adopted only when two consecutive measurements agree. One stray measurement changes no output.
- R3: Adopting a new class sets `mute_o` to 1 and `wake_n_o` to 0, both in the same cycle.
- R4: `dsd_o` follows the synchronised `dsd_i`. Each change of it raises the same event as R3.
- R5: `mute_o` and `wake_n_o` hold until a cycle in which `ack_i` = 1, and then release together in the next cycle. `ack_i` has no effect while no event is pending.
- R6: When an event and `ack_i` fall in the same cycle, the event wins and the outputs stay asserted for at least the next cycle.
- R7: With `osc_class_i` = 2 (highest pair), or 3, which behaves the same, `ratio_o` is 1024, 512, 256 or 128 for speed 1x, 2x, 4x or 8x, and `unsup_o` = 0.
- R8: With `osc_class_i` = 1 (middle pair), `ratio_o` is 512, 256 or 128 for 1x, 2x or 4x. At 8x, `unsup_o` = 1 and `ratio_o` = 0.
- R9: With `osc_class_i` = 0 (lowest pair), `ratio_o` is 256 or 128 for 1x or 2x. At 4x and 8x, `unsup_o` = 1 and `ratio_o` = 0.
- R10: `fam_sel_o` equals the adopted family and picks the oscillator (0 = 44.1 kHz series).
- R11: If no word-clock edge arrives for longer than the slowest window allows, the measurement is invalid. Two such measurements in a row adopt the invalid class: `rate_ok_o` = 0, `ratio_o` = 0, `unsup_o` = 0, and an event is raised.
- R12: After reset, `mute_o` = 0, `wake_n_o` = 1, `rate_ok_o` = 0, `dsd_o` = 0 and `ratio_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, the measurement reference |
| rst_n | input | 1 | Active-low synchronous reset |
| wclk_i | input | 1 | Word clock of the incoming stream, asynchronous |
| dsd_i | input | 1 | Stream-format flag, 1 = DSD, asynchronous |
| osc_class_i | input | 2 | Speed class of the fitted oscillator pair |
| ack_i | input | 1 | Controller acknowledge |
| mute_o | output | 1 | Mute request for the serial output |
| wake_n_o | output | 1 | Active-low wake line to the controller |
| dsd_o | output | 1 | Stream is DSD |
| rate_ok_o | output | 1 | Adopted rate class is valid |
| rate_code_o | output | 3 | Family and speed of the adopted rate |
| fam_sel_o | output | 1 | Oscillator select by family |
| ratio_o | output | 11 | Master-clock ratio in multiples of Fs, 0 if none |
| unsup_o | output | 1 | Rate not supported by the fitted oscillator pair |

## Verification
The controller's acknowledge and a new change event can land in the same cycle, and the event must take priority. The bench holds `ack_i` high without a break and then flips `dsd_i`. The synchronised change then meets an active acknowledge in the cycle it is detected. The result is judged by counting `mute_o` high cycles in the window that follows: exactly one cycle shows the event survived the acknowledge and that the next acknowledged cycle cleared it. `mute_o` must also be low before the flip, which shows that the held acknowledge did nothing on its own.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam int RATIO_W = 11;
  localparam int NCLS    = 8;

  typedef struct packed {
    logic       ok;
    logic       fam;
    logic [1:0] spd;
  } rate_cls_t;

  // nominal count of local cycles for NPER periods of class idx
  function automatic longint exp_count(longint clk_hz, longint nper, int idx);
    longint rate;
    rate = ((idx >= 4) ? 64'd48000 : 64'd44100) << (idx & 3);
    return (nper * clk_hz) / rate;
  endfunction
endpackage

// File: rtl/srw_sync.sv
module srw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/srw_meter.sv
module srw_meter
  import srw_pkg::*;
#(
  parameter longint CLK_HZ  = 24_576_000,
  parameter int     NPER    = 4,
  parameter int     TOL_PCT = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      edge_i,
  output logic      done_o,
  output rate_cls_t cls_o
);
  localparam longint SLOW = exp_count(CLK_HZ, longint'(NPER), 0);
  localparam longint CMAX = SLOW + (SLOW * TOL_PCT) / 100 + 1;
  localparam int     CW   = $clog2(CMAX + 1);
  localparam int     EW   = (NPER > 1) ? $clog2(NPER) : 1;

  logic [CW-1:0]   cnt_q;
  logic [EW-1:0]   ecnt_q;
  logic [NCLS-1:0] hit;
  rate_cls_t       enc;

  for (genvar g = 0; g < NCLS; g++) begin : g_win
    localparam longint EXP = exp_count(CLK_HZ, longint'(NPER), g);
    localparam longint LO  = EXP - (EXP * TOL_PCT) / 100;
    localparam longint HI  = EXP + (EXP * TOL_PCT) / 100;
    assign hit[g] = (cnt_q >= CW'(LO)) && (cnt_q <= CW'(HI));
  end

  always_comb begin
    enc = '0;
    for (int i = 0; i < NCLS; i++)
      if (hit[i]) enc = rate_cls_t'({1'b1, 3'(i)});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ecnt_q <= '0;
      done_o <= 1'b0;
      cls_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (edge_i) begin
        if (ecnt_q == EW'(NPER - 1)) begin
          done_o <= 1'b1;
          cls_o  <= enc;
          cnt_q  <= CW'(1);
          ecnt_q <= '0;
        end else begin
          ecnt_q <= ecnt_q + 1'b1;
          cnt_q  <= cnt_q + 1'b1;
        end
      end else if (cnt_q == CW'(CMAX)) begin
        done_o <= 1'b1;
        cls_o  <= '0;
        cnt_q  <= CW'(1);
        ecnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R1: the tolerance windows never overlap, so at most one class matches
  a_r1_one_window: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  // R11: a timeout restarts the window and reports an invalid class
  a_r11_timeout_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_i && cnt_q == CW'(CMAX)) |=> (done_o && !cls_o.ok));
endmodule

// File: rtl/srw_ctrl.sv
module srw_ctrl
  import srw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      meas_done_i,
  input  rate_cls_t meas_cls_i,
  input  logic      dsd_s_i,
  input  logic      ack_i,
  output rate_cls_t stable_o,
  output logic      dsd_o,
  output logic      pend_o
);
  rate_cls_t last_q;
  logic      have_last_q;
  logic      rate_evt, dsd_evt;

  assign rate_evt = meas_done_i && have_last_q &&
                    (meas_cls_i == last_q) && (meas_cls_i != stable_o);
  assign dsd_evt  = (dsd_s_i != dsd_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q      <= '0;
      have_last_q <= 1'b0;
      stable_o    <= '0;
      dsd_o       <= 1'b0;
      pend_o      <= 1'b0;
    end else begin
      if (meas_done_i) begin
        last_q      <= meas_cls_i;
        have_last_q <= 1'b1;
      end
      if (rate_evt) stable_o <= meas_cls_i;
      dsd_o <= dsd_s_i;
      if (rate_evt || dsd_evt) pend_o <= 1'b1;
      else if (ack_i)          pend_o <= 1'b0;
    end
  end

  // R2: the adopted class moves only on a second matching measurement
  a_r2_two_match: assert property (@(posedge clk) disable iff (!rst_n)
    (stable_o != $past(stable_o)) |->
      ($past(meas_done_i) && $past(have_last_q) && ($past(meas_cls_i) == $past(last_q))));

  // R3: a pending request only starts from a change event
  a_r3_rise_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o) |-> $past(rate_evt || dsd_evt));

  // R4: the reported format flag changes only together with an event
  a_r4_dsd_event: assert property (@(posedge clk) disable iff (!rst_n)
    (dsd_o != $past(dsd_o)) |-> pend_o);

  // R5: release only after an acknowledge
  a_r5_release_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_o) |-> $past(ack_i));

  // R6: an event beats a simultaneous acknowledge
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && (rate_evt || dsd_evt)) |=> pend_o);
endmodule

// File: rtl/srw_ratio.sv
module srw_ratio
  import srw_pkg::*;
(
  input  logic               ok_i,
  input  logic [1:0]         spd_i,
  input  logic [1:0]         osc_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               unsup_o
);
  logic [1:0] eff;
  logic [2:0] top_spd;

  always_comb begin
    eff     = (osc_i == 2'd3) ? 2'd2 : osc_i;
    top_spd = {1'b0, eff} + 3'd1;
    unsup_o = ok_i && ({1'b0, spd_i} > top_spd);
    if (ok_i && !unsup_o)
      ratio_o = (RATIO_W'(256) << eff) >> spd_i;
    else
      ratio_o = '0;
  end

  // R8/R9: an unsupported rate never carries a ratio
  always_comb begin
    a_r9_unsup_zero: assert (!(unsup_o && ratio_o != '0));
    a_r7_one_ratio:  assert ($onehot0(ratio_o));
  end
endmodule

// File: rtl/srate_watch.sv
module srate_watch
  import srw_pkg::*;
#(
  parameter longint CLK_HZ  = 24_576_000,
  parameter int     NPER    = 4,
  parameter int     TOL_PCT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wclk_i,
  input  logic               dsd_i,
  input  logic [1:0]         osc_class_i,
  input  logic               ack_i,
  output logic               mute_o,
  output logic               wake_n_o,
  output logic               dsd_o,
  output logic               rate_ok_o,
  output logic [2:0]         rate_code_o,
  output logic               fam_sel_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               unsup_o
);
  logic [1:0] synced;
  logic       wclk_prev_q, wedge;
  logic       meas_done, pend;
  rate_cls_t  meas_cls, stable;

  srw_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({dsd_i, wclk_i}), .q_o(synced)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) wclk_prev_q <= 1'b0;
    else        wclk_prev_q <= synced[0];
  end
  assign wedge = synced[0] && !wclk_prev_q;

  srw_meter #(.CLK_HZ(CLK_HZ), .NPER(NPER), .TOL_PCT(TOL_PCT)) u_meter (
    .clk(clk), .rst_n(rst_n), .edge_i(wedge), .done_o(meas_done), .cls_o(meas_cls)
  );

  srw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .meas_done_i(meas_done), .meas_cls_i(meas_cls),
    .dsd_s_i(synced[1]), .ack_i(ack_i), .stable_o(stable), .dsd_o(dsd_o), .pend_o(pend)
  );

  srw_ratio u_ratio (
    .ok_i(stable.ok), .spd_i(stable.spd), .osc_i(osc_class_i),
    .ratio_o(ratio_o), .unsup_o(unsup_o)
  );

  assign mute_o      = pend;
  assign wake_n_o    = !pend;
  assign rate_ok_o   = stable.ok;
  assign rate_code_o = {stable.fam, stable.spd};
  assign fam_sel_o   = stable.fam;

  // R10: oscillator select always tracks the reported family
  a_r10_fam_sel: assert property (@(posedge clk) disable iff (!rst_n)
    fam_sel_o == rate_code_o[2]);
endmodule

// File: tb/srate_watch_tb.sv
module srate_watch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPER       = 4;
  localparam int CMAX       = 2274;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wclk = 1'b0;
  logic        dsd = 1'b0;
  logic [1:0]  osc = 2'd2;
  logic        ack = 1'b0;
  logic        mute, wake_n, dsd_o, rate_ok, fam_sel, unsup;
  logic [2:0]  code;
  logic [10:0] ratio;

  int total = 0;
  int bad   = 0;
  int wper  = 0;
  int cyc   = 0;

  srate_watch dut_i (
    .clk(clk), .rst_n(rst_n), .wclk_i(wclk), .dsd_i(dsd), .osc_class_i(osc),
    .ack_i(ack), .mute_o(mute), .wake_n_o(wake_n), .dsd_o(dsd_o),
    .rate_ok_o(rate_ok), .rate_code_o(code), .fam_sel_o(fam_sel),
    .ratio_o(ratio), .unsup_o(unsup)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  // word-clock generator, changes on falling clock edges
  initial begin
    forever begin
      if (wper == 0) begin
        wclk = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = wper;
        wclk = 1'b1;
        repeat (p / 2) @(negedge clk);
        wclk = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung act=%0d exp<=190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // ratio table taken from R7, R8, R9; 0 = unsupported
  function automatic int exp_ratio(input int oc, input int spd);
    int e;
    e = (oc == 3) ? 2 : oc;
    case (e)
      2: case (spd) 0: return 1024; 1: return 512; 2: return 256; default: return 128; endcase
      1: case (spd) 0: return 512; 1: return 256; 2: return 128; default: return 0; endcase
      default: case (spd) 0: return 256; 1: return 128; default: return 0; endcase
    endcase
  endfunction

  task automatic do_ack();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
    @(negedge clk);
    chk("R5", "mute after ack", int'(mute), 0);
    chk("R5", "wake_n after ack", int'(wake_n), 1);
  endtask

  task automatic t_rate(input int p, input int fam, input int spd);
    int old;
    old = wper;
    @(negedge clk) wper = p;
    repeat (NPER * (old + 4 * p) + 200) @(negedge clk);
    chk("R1", "rate_ok", int'(rate_ok), 1);
    chk("R1", "rate_code", int'(code), fam * 4 + spd);
    chk("R10", "fam_sel", int'(fam_sel), fam);
    chk("R3", "mute on change", int'(mute), 1);
    chk("R3", "wake_n on change", int'(wake_n), 0);
    do_ack();
    for (int oc = 0; oc < 4; oc++) begin
      @(negedge clk) osc = 2'(oc);
      @(negedge clk);
      chk(oc == 0 ? "R9" : (oc == 1 ? "R8" : "R7"), "ratio", int'(ratio), exp_ratio(oc, spd));
      chk(oc == 0 ? "R9" : (oc == 1 ? "R8" : "R7"), "unsup", int'(unsup),
          exp_ratio(oc, spd) == 0 ? 1 : 0);
    end
    @(negedge clk) osc = 2'd2;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12", "mute", int'(mute), 0);
    chk("R12", "wake_n", int'(wake_n), 1);
    chk("R12", "rate_ok", int'(rate_ok), 0);
    chk("R12", "dsd_o", int'(dsd_o), 0);
    chk("R12", "ratio", int'(ratio), 0);
  endtask

  // a single short period spoils only one measurement
  task automatic t_glitch();
    int mutes;
    mutes = 0;
    @(posedge wclk);
    @(negedge clk) wper = 35;
    @(posedge wclk);
    @(negedge clk) wper = 279;
    for (int i = 0; i < NPER * 279 * 5; i++) begin
      @(negedge clk);
      if (mute) mutes++;
    end
    chk("R2", "mute cycles after glitch", mutes, 0);
    chk("R2", "rate_code kept", int'(code), 1);
    chk("R2", "rate_ok kept", int'(rate_ok), 1);
  endtask

  task automatic t_dsd();
    @(negedge clk) dsd = 1'b1;
    repeat (6) @(negedge clk);
    chk("R4", "dsd_o", int'(dsd_o), 1);
    chk("R4", "mute on format change", int'(mute), 1);
    chk("R4", "wake_n on format change", int'(wake_n), 0);
    do_ack();
  endtask

  task automatic t_coincide();
    int mutes;
    mutes = 0;
    @(negedge clk) ack = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5", "held ack with nothing pending", int'(mute), 0);
    dsd = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mute) mutes++;
    end
    chk("R6", "mute cycles when event meets ack", mutes, 1);
    chk("R4", "dsd_o back to PCM", int'(dsd_o), 0);
    @(negedge clk) ack = 1'b0;
  endtask

  task automatic t_timeout();
    @(negedge clk) wper = 0;
    repeat (3 * CMAX + NPER * 64 + 50) @(negedge clk);
    chk("R11", "rate_ok lost", int'(rate_ok), 0);
    chk("R11", "ratio", int'(ratio), 0);
    chk("R11", "unsup", int'(unsup), 0);
    chk("R11", "mute on loss", int'(mute), 1);
    do_ack();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rate(512, 1, 0);
    t_rate(279, 0, 1);
    t_glitch();
    t_rate(64, 1, 3);
    t_rate(139, 0, 2);
    t_rate(557, 0, 0);
    t_dsd();
    t_coincide();
    t_timeout();
    summary();
    $finish;
  end
endmodule